// File: doc/BRIEF.md
# Drive Interrupt Request Controller

This block produces the interrupt line that a disk drive presents to its host over a parallel register interface. The transfer sequencer reports interrupt opportunities: the start of a data block, or the completion of a command. A raise policy filters these according to the transfer style. When a request is accepted, a pending flag is set. The flag is shown on the interrupt pin only while this drive is selected and the host has left interrupts enabled. In every other case the pin is released so that the other drive on the cable can use it.

The host acknowledges the interrupt in one of three ways: it reads the primary status register, it writes a new command, or it sets the soft-reset bit. A hardware reset also clears the flag. A read of the alternate status register returns the same status information, but it is not an acknowledge and leaves the flag unchanged. The block does not build the tri-state buffer itself. It supplies a data value and a separate output enable, and the chip top instantiates the pad from these.

Top module: `intrq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending flag becomes 0 on that edge. After reset it stays 0 until a raise is accepted.
- R2: When the output is enabled, `irq_val` equals the pending flag. The output is enabled when `drv_sel`=1 and `irq_disable`=0, and with the default polarity this means `irq_oe`=1.
- R3: When `irq_disable`=1 or `drv_sel`=0, the output is released (`irq_oe`=0) and `irq_val`=0. This holds whether or not an interrupt is pending, and the pending flag is kept.
- R4: In PIO mode (`dma_mode`=0), a block-start raise (`raise_kind`=0) sets the pending flag on the next edge. The exception is the first block of a write-type command (`write_cmd`=1, `first_block`=1), where the raise is ignored.
- R5: In DMA mode (`dma_mode`=1), block-start raises are ignored. Only a completion raise (`raise_kind`=1) sets the flag.
- R6: A completion raise sets the pending flag in PIO mode as well.
- R7: A one-cycle `stat_rd`, a one-cycle `cmd_wr`, or `srst_bit`=1 clears the pending flag on the next edge.
- R8: `alt_stat_rd` has no effect on the pending flag.
- R9: When a clear event and an accepted raise occur in the same cycle, the clear wins and the flag is 0 afterwards.
- R10: An acknowledge that arrives while nothing is pending leaves the flag at 0, and a later raise still sets it.
- R11: Once set, the pending flag holds its value until a clear event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| raise_req | input | 1 | Interrupt opportunity strobe from the sequencer |
| raise_kind | input | 1 | 0 = data block start, 1 = command completion |
| dma_mode | input | 1 | Current command transfers by DMA |
| write_cmd | input | 1 | Current command is write-type |
| first_block | input | 1 | The block being started is the first of the command |
| srst_bit | input | 1 | Soft-reset bit from the control register |
| irq_disable | input | 1 | Interrupt-disable bit from the control register |
| drv_sel | input | 1 | This drive is the selected one |
| cmd_wr | input | 1 | Host write strobe of the command register |
| stat_rd | input | 1 | Host read strobe of the primary status register |
| alt_stat_rd | input | 1 | Host read strobe of the alternate status register |
| irq_val | output | 1 | Data value for the interrupt pad |
| irq_oe | output | 1 | Output enable for the interrupt pad |
| irq_pending | output | 1 | Pending interrupt flag |

## Verification
The sequencer can raise an interrupt in the same cycle that the host acknowledges one, so a set and a clear can fall together. The bench provokes this by asserting an accepted PIO block-start raise in the same cycle as a primary status read. It does this once with the flag clear and once with the flag already set, pairing the raise with a command write in the second case. Both cases are judged by the flag one cycle later, which must read 0. The bench also pulses an alternate-status read against a set flag, and the flag must then stay at 1.

// File: rtl/intrq_pkg.sv
// Shared types for the drive interrupt request controller.
package intrq_pkg;
    // Kind of interrupt opportunity reported by the sequencer.
    typedef enum logic {
        RAISE_BLOCK = 1'b0,
        RAISE_DONE  = 1'b1
    } raise_kind_e;
endpackage

// File: rtl/intrq_raise_policy.sv
// Raise policy: decides whether a sequencer strobe may set the pending flag.
// DMA commands interrupt only on completion. PIO commands interrupt at each
// block start, except the first block of a write-type command.
// Assumes the qualifiers are stable in the cycle of raise_req.
module intrq_raise_policy
    import intrq_pkg::*;
(
    input  logic        raise_req,
    input  raise_kind_e raise_kind,
    input  logic        dma_mode,
    input  logic        write_cmd,
    input  logic        first_block,
    output logic        raise_ok
);
    logic blk_allowed;

    // Filter block-start strobes by transfer style and block position.
    always_comb begin
        blk_allowed = !dma_mode && !(write_cmd && first_block);
        raise_ok    = raise_req &&
                      ((raise_kind == RAISE_DONE) || blk_allowed);
    end
endmodule

// File: rtl/intrq_clear_merge.sv
// Clear merge: collects the host actions that acknowledge an interrupt.
// The alternate-status read is deliberately not an input here.
// Assumes the strobes are single-cycle and the soft-reset bit is a level.
module intrq_clear_merge (
    input  logic cmd_wr,
    input  logic stat_rd,
    input  logic srst_bit,
    output logic clr_evt
);
    // Any acknowledging action produces a clear.
    always_comb begin
        clr_evt = cmd_wr || stat_rd || srst_bit;
    end
endmodule

// File: rtl/intrq_pending_reg.sv
// Pending flag: set by an accepted raise, cleared by reset or acknowledge.
// A clear takes priority over a set in the same cycle.
// Assumes a synchronous active-low reset.
module intrq_pending_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pending
);
    // Hold the flag. Clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (clr_evt) begin
            pending <= 1'b0;
        end else if (set_evt) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/intrq_out_gate.sv
// Output gate: drives the pad value and enable from the pending flag.
// The pin is driven only for the selected drive with interrupts enabled.
// OE_ACT_HIGH selects the enable polarity of the pad buffer at the top.
module intrq_out_gate #(
    parameter bit OE_ACT_HIGH = 1'b1
) (
    input  logic pending,
    input  logic drv_sel,
    input  logic irq_disable,
    output logic irq_val,
    output logic irq_oe
);
    logic drive_en;

    // Enable the pad and gate the value so that a released pin carries 0.
    always_comb begin
        drive_en = drv_sel && !irq_disable;
        irq_val  = pending && drive_en;
    end

    generate
        if (OE_ACT_HIGH) begin : g_oe_high
            // Enable output is active high.
            always_comb irq_oe = drive_en;
        end else begin : g_oe_low
            // Enable output is active low.
            always_comb irq_oe = !drive_en;
        end
    endgenerate
endmodule

// File: rtl/intrq_ctrl.sv
// Drive interrupt request controller, top level.
// Connects the raise policy, the clear merge, the pending flag and the
// output gate. The tri-state pad itself is built by the parent.
module intrq_ctrl #(
    parameter bit OE_ACT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_req,
    input  logic raise_kind,
    input  logic dma_mode,
    input  logic write_cmd,
    input  logic first_block,
    input  logic srst_bit,
    input  logic irq_disable,
    input  logic drv_sel,
    input  logic cmd_wr,
    input  logic stat_rd,
    input  logic alt_stat_rd,
    output logic irq_val,
    output logic irq_oe,
    output logic irq_pending
);
    import intrq_pkg::*;

    raise_kind_e kind_q;
    logic        raise_ok;
    logic        clr_evt;
    logic        alt_unused;

    // Map the raw kind bit onto the shared enum.
    always_comb begin
        kind_q     = raise_kind_e'(raise_kind);
        alt_unused = alt_stat_rd;
    end

    intrq_raise_policy u_policy (
        .raise_req   (raise_req),
        .raise_kind  (kind_q),
        .dma_mode    (dma_mode),
        .write_cmd   (write_cmd),
        .first_block (first_block),
        .raise_ok    (raise_ok)
    );

    intrq_clear_merge u_clear (
        .cmd_wr   (cmd_wr),
        .stat_rd  (stat_rd),
        .srst_bit (srst_bit),
        .clr_evt  (clr_evt)
    );

    intrq_pending_reg u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (raise_ok),
        .clr_evt (clr_evt),
        .pending (irq_pending)
    );

    intrq_out_gate #(.OE_ACT_HIGH(OE_ACT_HIGH)) u_gate (
        .pending     (irq_pending),
        .drv_sel     (drv_sel),
        .irq_disable (irq_disable),
        .irq_val     (irq_val),
        .irq_oe      (irq_oe)
    );
endmodule

// File: rtl/intrq_ctrl_chk.sv
// Checker for intrq_ctrl, attached by bind. Observes ports only.
module intrq_ctrl_chk #(
    parameter bit OE_ACT_HIGH = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic raise_req,
    input logic raise_kind,
    input logic dma_mode,
    input logic write_cmd,
    input logic first_block,
    input logic srst_bit,
    input logic irq_disable,
    input logic drv_sel,
    input logic cmd_wr,
    input logic stat_rd,
    input logic alt_stat_rd,
    input logic irq_val,
    input logic irq_oe,
    input logic irq_pending
);
    logic oe_on;
    logic any_clr;

    always_comb begin
        oe_on   = (irq_oe == OE_ACT_HIGH);
        any_clr = cmd_wr || stat_rd || srst_bit;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !irq_pending); // R1

    AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_on |-> (irq_val == irq_pending)); // R2

    AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_disable || !drv_sel) |-> (!oe_on && !irq_val)); // R3

    AST_WRITE_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_req && !raise_kind && !dma_mode && write_cmd && first_block && !irq_pending)
        |=> !irq_pending); // R4

    AST_DMA_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_req && !raise_kind && dma_mode && !irq_pending) |=> !irq_pending); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any_clr |=> !irq_pending); // R9

    AST_ALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_stat_rd && !any_clr && irq_pending) |=> irq_pending); // R8

    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !any_clr) |=> irq_pending); // R11
endmodule

bind intrq_ctrl intrq_ctrl_chk #(.OE_ACT_HIGH(OE_ACT_HIGH)) u_intrq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_req   (raise_req),
    .raise_kind  (raise_kind),
    .dma_mode    (dma_mode),
    .write_cmd   (write_cmd),
    .first_block (first_block),
    .srst_bit    (srst_bit),
    .irq_disable (irq_disable),
    .drv_sel     (drv_sel),
    .cmd_wr      (cmd_wr),
    .stat_rd     (stat_rd),
    .alt_stat_rd (alt_stat_rd),
    .irq_val     (irq_val),
    .irq_oe      (irq_oe),
    .irq_pending (irq_pending)
);

// File: tb/intrq_ctrl_bench.sv
// Directed bench for intrq_ctrl. Inputs change on the falling edge;
// outputs are sampled on the next falling edge, after one rising edge.
module intrq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n, raise_req, raise_kind, dma_mode, write_cmd, first_block;
    logic srst_bit, irq_disable, drv_sel, cmd_wr, stat_rd, alt_stat_rd;
    logic irq_val, irq_oe, irq_pending;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intrq_ctrl u_intrq_ctrl (
        .clk(clk), .rst_n(rst_n), .raise_req(raise_req), .raise_kind(raise_kind),
        .dma_mode(dma_mode), .write_cmd(write_cmd), .first_block(first_block),
        .srst_bit(srst_bit), .irq_disable(irq_disable), .drv_sel(drv_sel),
        .cmd_wr(cmd_wr), .stat_rd(stat_rd), .alt_stat_rd(alt_stat_rd),
        .irq_val(irq_val), .irq_oe(irq_oe), .irq_pending(irq_pending)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One-cycle raise with qualifiers; returns at the sampling point.
    task automatic raise(input logic kind, input logic dma, input logic wr, input logic first);
        raise_req = 1'b1; raise_kind = kind; dma_mode = dma;
        write_cmd = wr; first_block = first;
        tick();
        raise_req = 1'b0; dma_mode = 1'b0; write_cmd = 1'b0; first_block = 1'b0;
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic pulse_cmd();
        cmd_wr = 1'b1; tick(); cmd_wr = 1'b0;
    endtask

    task automatic t_reset();
        check(irq_pending, 1'b0, "R1 pending after reset");
        check(irq_val, 1'b0, "R1 value after reset");
        check(irq_oe, 1'b1, "R2 enable with sel and enabled");
        raise(1'b1, 1'b0, 1'b0, 1'b0);
        check(irq_pending, 1'b1, "R6 completion raise before hw reset");
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check(irq_pending, 1'b0, "R1 hw reset clears pending");
    endtask

    task automatic t_pio_block();
        raise(1'b0, 1'b0, 1'b0, 1'b1);
        check(irq_pending, 1'b1, "R4 PIO read first block raises");
        check(irq_val, 1'b1, "R2 value follows pending");
        pulse_stat();
        check(irq_pending, 1'b0, "R7 status read clears");
        check(irq_val, 1'b0, "R2 value low after clear");
    endtask

    task automatic t_write_first();
        raise(1'b0, 1'b0, 1'b1, 1'b1);
        check(irq_pending, 1'b0, "R4 write first block ignored");
        raise(1'b0, 1'b0, 1'b1, 1'b0);
        check(irq_pending, 1'b1, "R4 write later block raises");
        pulse_cmd();
        check(irq_pending, 1'b0, "R7 command write clears");
    endtask

    task automatic t_dma();
        raise(1'b0, 1'b1, 1'b0, 1'b1);
        check(irq_pending, 1'b0, "R5 DMA block start ignored");
        raise(1'b0, 1'b1, 1'b1, 1'b0);
        check(irq_pending, 1'b0, "R5 DMA write block ignored");
        raise(1'b1, 1'b1, 1'b0, 1'b0);
        check(irq_pending, 1'b1, "R5 DMA completion raises");
        srst_bit = 1'b1; tick(); srst_bit = 1'b0;
        check(irq_pending, 1'b0, "R7 soft reset clears");
        raise(1'b1, 1'b0, 1'b1, 1'b0);
        check(irq_pending, 1'b1, "R6 PIO completion raises");
        pulse_stat();
    endtask

    task automatic t_hiz();
        raise(1'b0, 1'b0, 1'b0, 1'b0);
        irq_disable = 1'b1; #1;
        check(irq_oe, 1'b0, "R3 released when disabled");
        check(irq_val, 1'b0, "R3 value low when disabled");
        check(irq_pending, 1'b1, "R3 pending kept when disabled");
        irq_disable = 1'b0; drv_sel = 1'b0; #1;
        check(irq_oe, 1'b0, "R3 released when not selected");
        check(irq_val, 1'b0, "R3 value low when not selected");
        drv_sel = 1'b1; #1;
        check(irq_oe, 1'b1, "R2 enable restored");
        check(irq_val, 1'b1, "R2 value restored");
        pulse_stat();
    endtask

    task automatic t_alt();
        raise(1'b0, 1'b0, 1'b0, 1'b0);
        alt_stat_rd = 1'b1; tick(); alt_stat_rd = 1'b0;
        check(irq_pending, 1'b1, "R8 alt read keeps pending");
        check(irq_val, 1'b1, "R8 alt read keeps pin");
        pulse_stat();
        alt_stat_rd = 1'b1; tick(); alt_stat_rd = 1'b0;
        check(irq_pending, 1'b0, "R8 alt read keeps clear");
    endtask

    task automatic t_collide();
        stat_rd = 1'b1;
        raise(1'b0, 1'b0, 1'b0, 1'b0);
        stat_rd = 1'b0;
        check(irq_pending, 1'b0, "R9 raise with status read");
        raise(1'b1, 1'b0, 1'b0, 1'b0);
        check(irq_pending, 1'b1, "R6 set before second collision");
        cmd_wr = 1'b1;
        raise(1'b0, 1'b0, 1'b0, 1'b0);
        cmd_wr = 1'b0;
        check(irq_pending, 1'b0, "R9 raise with command write");
    endtask

    task automatic t_idle_ack();
        pulse_stat();
        check(irq_pending, 1'b0, "R10 idle status read");
        pulse_cmd();
        check(irq_pending, 1'b0, "R10 idle command write");
        raise(1'b0, 1'b0, 1'b0, 1'b0);
        check(irq_pending, 1'b1, "R10 raise after idle ack");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) begin
            tick();
            check(irq_pending, 1'b1, "R11 pending holds");
        end
        pulse_stat();
        check(irq_pending, 1'b0, "R7 final clear");
    endtask

    initial begin
        rst_n = 1'b0; raise_req = 1'b0; raise_kind = 1'b0; dma_mode = 1'b0;
        write_cmd = 1'b0; first_block = 1'b0; srst_bit = 1'b0; irq_disable = 1'b0;
        drv_sel = 1'b1; cmd_wr = 1'b0; stat_rd = 1'b0; alt_stat_rd = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_pio_block();
        t_write_first();
        t_dma();
        t_hiz();
        t_alt();
        t_collide();
        t_idle_ack();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule